// File: doc/BRIEF.md
# Weighted Fair Output Scheduler

This block decides which of several flows may send its next packet on a shared output link. Each flow reports whether it has a packet at the head of its queue and how long that packet is. The scheduler gives every backlogged flow a virtual start tag and a virtual finish tag, and it keeps a system virtual time. A flow may be picked only once its start tag has been reached in virtual time. Among the flows that may be picked, the one with the earliest finish tag wins. Over time each flow receives a share of the link in proportion to its programmed weight. The link never stays idle while any flow holds a packet.

A grant shows the chosen flow and the length of its packet. The grant stays on the outputs until the transmitter pulses `tx_done`. That pulse charges the packet to the system virtual time and frees the flow to present its next packet. Weights are written one flow at a time through a small configuration port. The inverse of each weight is computed when the weight is written and is kept in a register.

Top module: `wfq_sched`

## Requirements
- R1: After reset `grant_valid` is 0, `vtime` is 0, every weight is 1 and every flow is idle.
- R2: A write with `cfg_we` high stores `cfg_weight` for flow `cfg_flow`, with a weight of 0 stored as 1. The inverse weight is set to floor(4096 / weight) (12 fractional bits).
- R3: A flow whose queue was empty starts at max(vtime, its previous finish tag). A flow that presents a new packet straight after a grant, without emptying, starts at its previous finish tag.
- R4: A packet's finish tag is its start tag plus length × inverse weight.
- R5: A flow is eligible when its start tag is at or before `vtime` (wrap-safe compare). A grant goes to the eligible flow with the smallest finish tag, and ties go to the lowest flow index.
- R6: `grant_valid`, `grant_flow` and `grant_len` hold steady until `tx_done`. The grant drops on the cycle after `tx_done`.
- R7: On `tx_done`, `vtime` advances by floor(grant_len × 4096 / W). W is the sum of the weights of all flows that are backlogged in that cycle, the granted flow included.
- R8: When flows are backlogged but none is eligible, `vtime` jumps to the smallest start tag among them. A grant is issued whenever some flow is eligible and no grant is outstanding.
- R9: `vtime` never moves backwards in the wrap-safe sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Weight write strobe |
| cfg_flow | input | 3 | Flow whose weight is written |
| cfg_weight | input | 8 | New weight value |
| flow_pending | input | 8 | Per-flow head-of-queue packet present |
| flow_len | input | 128 | Per-flow head packet length, 16 bits per flow, flow 0 in the low bits |
| tx_done | input | 1 | Transmission of the granted packet finished |
| grant_valid | output | 1 | A grant is outstanding |
| grant_flow | output | 3 | Granted flow index |
| grant_len | output | 16 | Length of the granted packet |
| vtime | output | 32 | System virtual time |

## Verification
Two things can happen in the same cycle: a new flow becomes backlogged, and the charge of a packet that was just sent is added to the virtual time. The weight sum used in that charge must count the newly arrived flow. The bench sets this up by pushing a packet into an idle flow while another flow's grant is still outstanding. It then judges the result from the final virtual time, which differs by a whole packet's charge if the new flow was left out of the sum. A second collision happens when a flow's previous finish tag lies ahead of the virtual time just as it returns from idle. The bench detects this through the grant order: a start tag taken from the virtual time alone would let that flow jump ahead of a flow with a very late finish tag.

// File: rtl/wfq_pkg.sv
package wfq_pkg;

    localparam int FLOWS  = 8;
    localparam int LEN_W  = 16;
    localparam int VT_W   = 32;
    localparam int WGT_W  = 8;
    localparam int FRAC_W = 12;

    typedef logic [VT_W-1:0] vtime_t;

    typedef struct packed {
        vtime_t start;
        vtime_t finish;
    } vtag_t;

    // wrap-safe a < b
    function automatic logic vt_lt(vtime_t a, vtime_t b);
        vtime_t d;
        d = a - b;
        return d[VT_W-1];
    endfunction

    // wrap-safe a <= b
    function automatic logic vt_le(vtime_t a, vtime_t b);
        return vt_lt(a, b) || (a == b);
    endfunction

endpackage

// File: rtl/wfq_weight_bank.sv
module wfq_weight_bank #(
    parameter int N    = wfq_pkg::FLOWS,
    parameter int WW   = wfq_pkg::WGT_W,
    parameter int FRAC = wfq_pkg::FRAC_W,
    localparam int IW   = $clog2(N),
    localparam int INVW = FRAC + 1,
    localparam int SW   = WW + IW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_flow,
    input  logic [WW-1:0]   cfg_weight,
    input  logic [N-1:0]    act,
    output logic [INVW-1:0] inv [N],
    output logic [SW-1:0]   sum_w
);
    localparam logic [INVW-1:0] UNIT = INVW'(1) << FRAC;

    logic [WW-1:0]   w_q   [N];
    logic [INVW-1:0] inv_q [N];
    logic [WW-1:0]   w_clamp;

    assign w_clamp = (cfg_weight == '0) ? WW'(1) : cfg_weight;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                w_q[i]   <= WW'(1);
                inv_q[i] <= UNIT;
            end
        end else if (cfg_we) begin
            w_q[cfg_flow]   <= w_clamp;
            inv_q[cfg_flow] <= UNIT / INVW'(w_clamp);
        end
    end

    always_comb begin
        sum_w = '0;
        for (int i = 0; i < N; i++) begin
            inv[i] = inv_q[i];
            if (act[i]) sum_w = sum_w + SW'(w_q[i]);
        end
    end

    // R2: a stored weight of zero would make the charge divide by zero
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                weight_nonzero_chk: assert (w_q[i] != '0);
            end
        end
    end

endmodule

// File: rtl/wfq_flow_tag.sv
module wfq_flow_tag #(
    parameter int LW   = wfq_pkg::LEN_W,
    parameter int FRAC = wfq_pkg::FRAC_W,
    localparam int INVW = FRAC + 1,
    localparam int PW   = LW + INVW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pending,
    input  logic [LW-1:0]        len,
    input  logic [INVW-1:0]      inv,
    input  wfq_pkg::vtime_t      vt,
    input  logic                 block,
    input  logic                 done_me,
    output wfq_pkg::vtag_t       tag,
    output logic [LW-1:0]        len_q,
    output logic                 active,
    output logic                 arrive
);
    import wfq_pkg::*;

    vtag_t  tag_q;
    logic   act_q;
    logic   cont_q;
    vtime_t st;
    logic [PW-1:0] prod;

    // R3: start tag selection
    always_comb begin
        if (cont_q)                 st = tag_q.finish;
        else if (vt_lt(vt, tag_q.finish)) st = tag_q.finish;
        else                        st = vt;
    end

    // R4: service cost in virtual time
    assign prod = {{INVW{1'b0}}, len} * {{LW{1'b0}}, inv};

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            act_q  <= 1'b0;
            cont_q <= 1'b0;
            len_q  <= '0;
        end else if (done_me) begin
            act_q  <= 1'b0;
            cont_q <= 1'b1;
        end else if (!block && !act_q) begin
            cont_q <= 1'b0;
            if (pending) begin
                act_q        <= 1'b1;
                tag_q.start  <= st;
                tag_q.finish <= st + VT_W'(prod);
                len_q        <= len;
            end
        end
    end

    assign tag    = tag_q;
    assign active = act_q;
    assign arrive = pending && !act_q && !block;

    // R4: a backlogged flow always has a finish tag no earlier than its start
    active_tag_order_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> vt_le(tag_q.start, tag_q.finish));

endmodule

// File: rtl/wfq_pick.sv
module wfq_pick #(
    parameter int N = wfq_pkg::FLOWS,
    localparam int IW = $clog2(N)
) (
    input  wfq_pkg::vtag_t  tags [N],
    input  logic [N-1:0]    act,
    input  wfq_pkg::vtime_t vt,
    output logic            any_elig,
    output logic [IW-1:0]   win,
    output logic            any_act,
    output wfq_pkg::vtime_t min_start
);
    import wfq_pkg::*;

    vtime_t best_f;

    // R5: earliest finish among eligible, strict compare keeps lowest index
    always_comb begin
        any_elig  = 1'b0;
        any_act   = 1'b0;
        win       = '0;
        best_f    = '0;
        min_start = '0;
        for (int i = 0; i < N; i++) begin
            if (act[i]) begin
                if (!any_act || vt_lt(tags[i].start, min_start))
                    min_start = tags[i].start;
                any_act = 1'b1;
                if (vt_le(tags[i].start, vt)) begin
                    if (!any_elig || vt_lt(tags[i].finish, best_f)) begin
                        best_f = tags[i].finish;
                        win    = IW'(i);
                    end
                    any_elig = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wfq_sched.sv
module wfq_sched #(
    parameter int N    = wfq_pkg::FLOWS,
    parameter int LW   = wfq_pkg::LEN_W,
    parameter int WW   = wfq_pkg::WGT_W,
    parameter int FRAC = wfq_pkg::FRAC_W,
    localparam int IW   = $clog2(N),
    localparam int INVW = FRAC + 1,
    localparam int SW   = WW + IW,
    localparam int QW   = LW + FRAC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [IW-1:0]               cfg_flow,
    input  logic [WW-1:0]               cfg_weight,
    input  logic [N-1:0]                flow_pending,
    input  logic [N*LW-1:0]             flow_len,
    input  logic                        tx_done,
    output logic                        grant_valid,
    output logic [IW-1:0]               grant_flow,
    output logic [LW-1:0]               grant_len,
    output logic [wfq_pkg::VT_W-1:0]    vtime
);
    import wfq_pkg::*;

    logic            busy_q;
    logic            settle_q;
    logic [IW-1:0]   gidx_q;
    vtime_t          vt_q;

    vtag_t           tags  [N];
    logic [LW-1:0]   lens  [N];
    logic [INVW-1:0] inv_w [N];
    logic [N-1:0]    act;
    logic [N-1:0]    arrive;
    logic [SW-1:0]   sum_w;

    logic            any_elig;
    logic            any_act;
    logic [IW-1:0]   win;
    vtime_t          min_start;
    logic            sel_ok;
    logic            finish_now;
    logic [QW-1:0]   charge;

    wfq_weight_bank #(.N(N), .WW(WW), .FRAC(FRAC)) u_wbank (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_flow   (cfg_flow),
        .cfg_weight (cfg_weight),
        .act        (act),
        .inv        (inv_w),
        .sum_w      (sum_w)
    );

    for (genvar g = 0; g < N; g++) begin : g_flow
        wfq_flow_tag #(.LW(LW), .FRAC(FRAC)) u_tag (
            .clk     (clk),
            .rst     (rst),
            .pending (flow_pending[g]),
            .len     (flow_len[g*LW +: LW]),
            .inv     (inv_w[g]),
            .vt      (vt_q),
            .block   (settle_q && (gidx_q == IW'(g))),
            .done_me (finish_now && (gidx_q == IW'(g))),
            .tag     (tags[g]),
            .len_q   (lens[g]),
            .active  (act[g]),
            .arrive  (arrive[g])
        );
    end

    wfq_pick #(.N(N)) u_pick (
        .tags      (tags),
        .act       (act),
        .vt        (vt_q),
        .any_elig  (any_elig),
        .win       (win),
        .any_act   (any_act),
        .min_start (min_start)
    );

    assign finish_now = busy_q && tx_done;
    assign sel_ok     = !busy_q && !settle_q && (arrive == '0);
    // R7: charge of the finished packet against the backlogged weight sum
    assign charge     = {lens[gidx_q], {FRAC{1'b0}}} /
                        ((sum_w == '0) ? QW'(1) : QW'(sum_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            settle_q <= 1'b0;
            gidx_q   <= '0;
            vt_q     <= '0;
        end else begin
            settle_q <= finish_now;
            if (finish_now) begin
                busy_q <= 1'b0;
                vt_q   <= vt_q + VT_W'(charge);
            end else if (sel_ok) begin
                if (any_elig) begin
                    busy_q <= 1'b1;
                    gidx_q <= win;
                end else if (any_act) begin
                    vt_q   <= min_start;
                end
            end
        end
    end

    assign grant_valid = busy_q;
    assign grant_flow  = gidx_q;
    assign grant_len   = lens[gidx_q];
    assign vtime       = vt_q;

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tx_done) |=> (busy_q && $stable(gidx_q) && $stable(grant_len)));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && tx_done) |=> !busy_q);

    // R5
    grant_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (act[gidx_q] && vt_le(tags[gidx_q].start, vt_q)));

    // R8
    work_conserving_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !settle_q && (arrive == '0) && any_elig) |=> busy_q);

    // R9
    vtime_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !vt_lt(vt_q, $past(vt_q)));

endmodule

// File: tb/wfq_sched_bench.sv
module wfq_sched_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N  = 8;
    localparam int LW = 16;

    typedef struct {
        int    flow;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_flow = '0;
    logic [7:0]    cfg_weight = '0;
    logic [N-1:0]  flow_pending = '0;
    logic [N*LW-1:0] flow_len = '0;
    logic          tx_done = 1'b0;
    logic          grant_valid;
    logic [2:0]    grant_flow;
    logic [LW-1:0] grant_len;
    logic [31:0]   vtime;

    int   checks = 0;
    int   fails  = 0;
    bit   in_flight = 0;
    bit   done_run = 0;
    int   fq [N][$];
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    wfq_sched u_wfq_sched (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_flow     (cfg_flow),
        .cfg_weight   (cfg_weight),
        .flow_pending (flow_pending),
        .flow_len     (flow_len),
        .tx_done      (tx_done),
        .grant_valid  (grant_valid),
        .grant_flow   (grant_flow),
        .grant_len    (grant_len),
        .vtime        (vtime)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic void drive_pins();
        for (int i = 0; i < N; i++) begin
            flow_pending[i] = (fq[i].size() > 0);
            flow_len[i*LW +: LW] = (fq[i].size() > 0) ? LW'(fq[i][0]) : '0;
        end
    endfunction

    task automatic push_pkt(input int f, input int l);
        fq[f].push_back(l);
        drive_pins();
    endtask

    task automatic expect_grant(input int f, input string req);
        exp_t e;
        e.flow = f;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic set_weight(input int f, input int w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_flow = 3'(f);
        cfg_weight = 8'(w);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < N; i++) fq[i].delete();
        exp_q.delete();
        drive_pins();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || in_flight || grant_valid) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // monitor: pops the expected grant order and acknowledges each grant
    initial begin
        forever begin
            @(negedge clk);
            if (grant_valid && !rst) begin
                int    g;
                int    gl;
                int    head;
                exp_t  e;
                in_flight = 1;
                g  = int'(grant_flow);
                gl = int'(grant_len);
                if (exp_q.size() == 0) begin
                    check("R5", "unexpected grant flow", g, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, "grant flow", g, e.flow);
                end
                head = (fq[g].size() > 0) ? fq[g][0] : -1;
                check("R6", "grant length", gl, head);
                repeat (2) @(negedge clk);
                // R6: grant held while transmission runs
                check("R6", "held grant", {grant_valid, grant_flow, grant_len},
                      {1'b1, 3'(g), LW'(gl)});
                tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0;
                check("R6", "grant released", grant_valid, 0);
                if (fq[g].size() > 0) void'(fq[g].pop_front());
                drive_pins();
                in_flight = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        drive_pins();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "grant_valid after reset", grant_valid, 0);
        check("R1", "vtime after reset", vtime, 0);

        // single flow, unit weight: finish = 10*4096, charge = 10*4096/1
        push_pkt(3, 10);
        expect_grant(3, "R4");
        drain();
        check("R7", "vtime after one packet", vtime, 40960);

        // R8: two flows weights 2 and 1, steady backlog, includes a virtual-time jump
        reset_dut();
        set_weight(0, 2);
        set_weight(1, 1);
        expect_grant(0, "R8");
        expect_grant(1, "R8");
        expect_grant(0, "R8");
        expect_grant(0, "R8");
        expect_grant(1, "R8");
        expect_grant(1, "R8");
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            push_pkt(0, 8);
            push_pkt(1, 8);
        end
        drain();
        check("R8", "vtime after weighted run", vtime, 109226);

        // R3: idle return keeps a finish tag that lies ahead of vtime
        reset_dut();
        set_weight(1, 4);
        expect_grant(1, "R5");
        expect_grant(0, "R5");
        expect_grant(1, "R3");
        @(negedge clk);
        push_pkt(0, 4);
        push_pkt(1, 4);
        push_pkt(1, 4);
        drain();
        check("R7", "vtime mid idle-return test", vtime, 10648);
        expect_grant(1, "R3");
        expect_grant(0, "R3");
        @(negedge clk);
        push_pkt(0, 4);
        push_pkt(1, 64);
        drain();
        check("R3", "vtime after idle return", vtime, 79460);

        // R5 tie to lowest index; R2 weight 0 acts as weight 1
        reset_dut();
        set_weight(2, 0);
        expect_grant(2, "R5");
        expect_grant(5, "R5");
        @(negedge clk);
        push_pkt(5, 4);
        push_pkt(2, 4);
        drain();
        check("R2", "vtime with clamped zero weight", vtime, 24576);

        // R7: arrival while a grant is outstanding joins the weight sum
        reset_dut();
        expect_grant(1, "R7");
        expect_grant(6, "R7");
        @(negedge clk);
        push_pkt(1, 8);
        wait (grant_valid);
        @(negedge clk);
        push_pkt(6, 8);
        drain();
        check("R7", "vtime with arrival during grant", vtime, 49152);

        // R9: vtime never fell during the run (also guarded by an assertion)
        check("R9", "vtime nonzero at end", (vtime != 0), 1);

        finish_run();
    end

endmodule